// File: doc/BRIEF.md
# Interrupt Distributor

This block gathers interrupt requests from shared peripheral lines and from software writes, holds per-interrupt state (enable, pending, active, priority, routing, trigger mode), and presents to each CPU interface the most urgent interrupt that is pending, enabled, not already in service and routed to that CPU. Software programs it over a simple 32-bit register bus with word addresses, read and write strobes, and an accessor CPU number. Each CPU interface answers with an acknowledge, which takes the offered interrupt into service, and later with an end-of-interrupt carrying the ID, which releases it.

The ID space is split in two. The lowest 32 IDs are private: each CPU owns its own enable, pending and active copy of them, and they are raised only by the software-interrupt register. The IDs from 32 upward are shared: they are driven by the `irq_in` lines, routed by a per-ID CPU mask, and may be level- or edge-triggered. The defaults give 64 IDs and 2 CPUs; at least 64 IDs are needed, and the register windows below allow up to 128.

Top module: `irq_distributor`

## Requirements
- R1: Bit 0 of the control word (address 0x00) is a global enable, 0 after reset; while it is 0 no CPU output is valid, whatever the interrupt state.
- R2: The enable bit of ID i lives in bit i%32 of word 0x10+i/32 (set view) and of word 0x18+i/32 (clear view). A 1 written in the set view enables, a 1 written in the clear view disables, a 0 changes nothing, and both views read back the current enable bits. All enables are 0 after reset.
- R3: The priority of ID i is byte i%4 (bits 8*(i%4)+7..8*(i%4)) of word 0x40+i/4, readable and writable, 0 after reset.
- R4: The routing mask of a shared ID i is byte i%4 of word 0x60+i/4; bit n set sends it to CPU n only. Routing bytes of private IDs are read-only and read as a byte with only the accessing CPU's bit set.
- R5: Shared ID i has a two-bit trigger field at bits 2*(i%16)+1..2*(i%16) of word 0x80+i/16. Its upper bit at 1 selects edge mode (a rising input edge latches pending); at 0, the reset value, the ID is level-sensitive (pending follows the input). Trigger words of private IDs read as 0 and ignore writes.
- R6: Word 0x01 is read-only; bits 4:0 hold NUM_IDS/32-1, all other bits read 0.
- R7: Private IDs 0..31 have enable, pending and active bits per CPU; a register access from CPU n (bus_cpu) sees and changes only CPU n's copy, and CPU n's output only considers its own copy.
- R8: A write to word 0x02 makes the private ID in bits 4:0 pending on every CPU n whose bit 16+n is set.
- R9: Of the IDs that are pending, enabled, not active and routed to a CPU, the one with the lowest priority value is offered with its ID and priority; equal priorities go to the lowest ID.
- R10: An acknowledge while an ID is offered makes it active (edge-mode and private IDs also lose pending), so it is no longer offered; an end-of-interrupt with that ID clears active, after which a level input still high is offered again.
- R11: Register words for IDs at or above NUM_IDS read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cpu | input | CPU_W | CPU number of the register access |
| bus_addr | input | 8 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_in | input | NUM_IDS-32 | Shared interrupt lines, bit k is ID 32+k |
| cpu_ack | input | NUM_CPUS | Acknowledge of the offered interrupt, per CPU |
| cpu_eoi | input | NUM_CPUS | End-of-interrupt strobe, per CPU |
| cpu_eoi_id | input | NUM_CPUS*ID_W | ID released by each end-of-interrupt |
| fwd_valid | output | NUM_CPUS | An interrupt is offered to CPU n |
| fwd_id | output | NUM_CPUS*ID_W | Offered ID, field n for CPU n |
| fwd_prio | output | NUM_CPUS*8 | Priority of the offered ID, field n for CPU n |

## Verification
Register writes, acknowledges and end-of-interrupts change state at one clock edge and the CPU outputs reflect it right after that edge, because the outputs are combinational from state; read data is registered and is due one edge after the read strobe. A change on irq_in goes through one input register before the pending bit, so its effect on the outputs is due two edges later. The bench drives every stimulus on a falling edge and compares on a later falling edge counted to those latencies, waiting an extra edge only where an input change must settle.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int PRIV_IDS = 32;
    localparam int PRIO_W   = 8;

    // word addresses of the single registers
    localparam logic [7:0] ADR_CTRL = 8'h00;
    localparam logic [7:0] ADR_TYPE = 8'h01;
    localparam logic [7:0] ADR_SOFT = 8'h02;

    // upper address bits selecting each register window
    localparam logic [4:0] WIN_ENSET = 5'b00010;  // 0x10..0x17
    localparam logic [4:0] WIN_ENCLR = 5'b00011;  // 0x18..0x1f
    localparam logic [2:0] WIN_PRIO  = 3'b010;    // 0x40..0x5f
    localparam logic [2:0] WIN_TGT   = 3'b011;    // 0x60..0x7f
    localparam logic [4:0] WIN_CFG   = 5'b10000;  // 0x80..0x87

endpackage

// File: rtl/irq_dist_sync.sv
module irq_dist_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prv;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d     = smp_q;
        smp_d.cur = raw;
        smp_d.prv = smp_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign lvl  = smp_q.cur;
    assign rise = smp_q.cur & ~smp_q.prv;

endmodule

// File: rtl/irq_dist_pick.sv
module irq_dist_pick #(
    parameter  int NUM_IDS = 64,
    parameter  int PRIO_W  = 8,
    localparam int ID_W    = $clog2(NUM_IDS)
) (
    input  logic [NUM_IDS-1:0]        elig,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
    output logic                      hit,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio
);

    // scan from the top ID down; "<=" lets a lower ID take a tie
    always_comb begin
        hit      = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = NUM_IDS - 1; i >= 0; i--) begin
            if (elig[i] && (!hit || prio_flat[i*PRIO_W +: PRIO_W] <= win_prio)) begin
                hit      = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
        if (!hit) win_prio = '0;
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter  int NUM_IDS  = 64,
    parameter  int NUM_CPUS = 2,
    localparam int ID_W     = $clog2(NUM_IDS),
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SH       = NUM_IDS - PRIV_IDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CPU_W-1:0]           bus_cpu,
    input  logic [7:0]                 bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [SH-1:0]              irq_in,
    input  logic [NUM_CPUS-1:0]        cpu_ack,
    input  logic [NUM_CPUS-1:0]        cpu_eoi,
    input  logic [NUM_CPUS*ID_W-1:0]   cpu_eoi_id,
    output logic [NUM_CPUS-1:0]        fwd_valid,
    output logic [NUM_CPUS*ID_W-1:0]   fwd_id,
    output logic [NUM_CPUS*PRIO_W-1:0] fwd_prio
);

    localparam int PV     = PRIV_IDS;
    localparam int SOFT_W = $clog2(PRIV_IDS);

    typedef struct packed {
        logic                             ctrl_en;
        logic [SH-1:0]                    en_sh;
        logic [SH-1:0]                    pend_sh;
        logic [SH-1:0]                    act_sh;
        logic [NUM_CPUS-1:0][PV-1:0]      en_pv;
        logic [NUM_CPUS-1:0][PV-1:0]      pend_pv;
        logic [NUM_CPUS-1:0][PV-1:0]      act_pv;
        logic [NUM_IDS-1:0][PRIO_W-1:0]   prio;
        logic [SH-1:0][7:0]               tgt;
        logic [SH-1:0][1:0]               cfg;
        logic [31:0]                      rdata;
    } dist_t;

    dist_t st_d, st_q;

    logic [SH-1:0] in_lvl, in_rise;

    irq_dist_sync #(.W(SH)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (irq_in),
        .lvl  (in_lvl),
        .rise (in_rise)
    );

    // ---------------- eligibility and selection per CPU ----------------
    logic [NUM_CPUS-1:0][NUM_IDS-1:0] elig;
    logic [NUM_CPUS-1:0]              pick_hit;
    logic [NUM_CPUS-1:0][ID_W-1:0]    pick_id;
    logic [NUM_CPUS-1:0][PRIO_W-1:0]  pick_prio;
    logic [NUM_IDS*PRIO_W-1:0]        prio_flat;

    assign prio_flat = st_q.prio;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        always_comb begin
            for (int i = 0; i < PV; i++)
                elig[c][i] = st_q.ctrl_en & st_q.en_pv[c][i] & st_q.pend_pv[c][i]
                             & ~st_q.act_pv[c][i];
            for (int j = 0; j < SH; j++)
                elig[c][PV+j] = st_q.ctrl_en & st_q.en_sh[j] & st_q.pend_sh[j]
                                & ~st_q.act_sh[j] & st_q.tgt[j][c];
        end

        irq_dist_pick #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) i_pick (
            .elig     (elig[c]),
            .prio_flat(prio_flat),
            .hit      (pick_hit[c]),
            .win_id   (pick_id[c]),
            .win_prio (pick_prio[c])
        );

        assign fwd_valid[c]                 = pick_hit[c];
        assign fwd_id[c*ID_W +: ID_W]       = pick_id[c];
        assign fwd_prio[c*PRIO_W +: PRIO_W] = pick_prio[c];
    end

    // ---------------- address decode ----------------
    logic is_ctrl, is_type, is_soft, is_enset, is_enclr, is_prio, is_tgt, is_cfg;

    always_comb begin
        is_ctrl  = (bus_addr == ADR_CTRL);
        is_type  = (bus_addr == ADR_TYPE);
        is_soft  = (bus_addr == ADR_SOFT);
        is_enset = (bus_addr[7:3] == WIN_ENSET);
        is_enclr = (bus_addr[7:3] == WIN_ENCLR);
        is_prio  = (bus_addr[7:5] == WIN_PRIO);
        is_tgt   = (bus_addr[7:5] == WIN_TGT);
        is_cfg   = (bus_addr[7:3] == WIN_CFG);
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;

        // shared pending from the sampled lines
        for (int j = 0; j < SH; j++) begin
            if (!st_q.cfg[j][1]) st_d.pend_sh[j] = in_lvl[j];
            else if (in_rise[j]) st_d.pend_sh[j] = 1'b1;
        end

        // end-of-interrupt releases, before acknowledges take hold
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (cpu_eoi[c]) begin
                for (int i = 0; i < PV; i++)
                    if (cpu_eoi_id[c*ID_W +: ID_W] == ID_W'(i)) st_d.act_pv[c][i] = 1'b0;
                for (int j = 0; j < SH; j++)
                    if (cpu_eoi_id[c*ID_W +: ID_W] == ID_W'(PV + j)) st_d.act_sh[j] = 1'b0;
            end
        end

        // acknowledges of the offered interrupt
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (cpu_ack[c] && pick_hit[c]) begin
                for (int i = 0; i < PV; i++)
                    if (pick_id[c] == ID_W'(i)) begin
                        st_d.act_pv[c][i]  = 1'b1;
                        st_d.pend_pv[c][i] = 1'b0;
                    end
                for (int j = 0; j < SH; j++)
                    if (pick_id[c] == ID_W'(PV + j)) begin
                        st_d.act_sh[j] = 1'b1;
                        if (st_q.cfg[j][1] && !in_rise[j]) st_d.pend_sh[j] = 1'b0;
                    end
            end
        end

        // register writes
        if (bus_wr) begin
            if (is_ctrl) st_d.ctrl_en = bus_wdata[0];

            if (is_soft) begin
                for (int c = 0; c < NUM_CPUS; c++)
                    if (bus_wdata[16+c])
                        for (int i = 0; i < PV; i++)
                            if (bus_wdata[SOFT_W-1:0] == SOFT_W'(i)) st_d.pend_pv[c][i] = 1'b1;
            end

            if (is_enset || is_enclr) begin
                for (int c = 0; c < NUM_CPUS; c++)
                    if (bus_cpu == CPU_W'(c) && bus_addr[2:0] == 3'd0)
                        for (int i = 0; i < PV; i++)
                            if (bus_wdata[i]) st_d.en_pv[c][i] = is_enset;
                for (int j = 0; j < SH; j++)
                    if (bus_addr[2:0] == 3'((PV + j) / 32) && bus_wdata[(PV + j) % 32])
                        st_d.en_sh[j] = is_enset;
            end

            if (is_prio) begin
                for (int i = 0; i < NUM_IDS; i++)
                    if (bus_addr[4:0] == 5'(i / 4))
                        st_d.prio[i] = bus_wdata[8*(i%4) +: 8];
            end

            if (is_tgt) begin
                for (int j = 0; j < SH; j++)
                    if (bus_addr[4:0] == 5'((PV + j) / 4))
                        st_d.tgt[j] = bus_wdata[8*((PV + j)%4) +: 8];
            end

            if (is_cfg) begin
                for (int j = 0; j < SH; j++)
                    if (bus_addr[2:0] == 3'((PV + j) / 16))
                        st_d.cfg[j] = bus_wdata[2*((PV + j)%16) +: 2];
            end
        end

        // register reads, answered on the next cycle
        st_d.rdata = '0;
        if (bus_rd) begin
            if (is_ctrl) st_d.rdata[0] = st_q.ctrl_en;
            if (is_type) st_d.rdata[4:0] = 5'(NUM_IDS / 32 - 1);

            if (is_enset || is_enclr) begin
                for (int c = 0; c < NUM_CPUS; c++)
                    if (bus_cpu == CPU_W'(c) && bus_addr[2:0] == 3'd0)
                        st_d.rdata = st_q.en_pv[c];
                for (int j = 0; j < SH; j++)
                    if (bus_addr[2:0] == 3'((PV + j) / 32))
                        st_d.rdata[(PV + j) % 32] = st_q.en_sh[j];
            end

            if (is_prio) begin
                for (int i = 0; i < NUM_IDS; i++)
                    if (bus_addr[4:0] == 5'(i / 4))
                        st_d.rdata[8*(i%4) +: 8] = st_q.prio[i];
            end

            if (is_tgt) begin
                for (int i = 0; i < PV; i++)
                    if (bus_addr[4:0] == 5'(i / 4))
                        for (int c = 0; c < NUM_CPUS; c++)
                            st_d.rdata[8*(i%4) + c] = (bus_cpu == CPU_W'(c));
                for (int j = 0; j < SH; j++)
                    if (bus_addr[4:0] == 5'((PV + j) / 4))
                        st_d.rdata[8*((PV + j)%4) +: 8] = st_q.tgt[j];
            end

            if (is_cfg) begin
                for (int j = 0; j < SH; j++)
                    if (bus_addr[2:0] == 3'((PV + j) / 16))
                        st_d.rdata[2*((PV + j)%16) +: 2] = st_q.cfg[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // ---------------- assertions ----------------
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
        // R1: nothing offered while the global enable is off
        a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_valid[c] |-> st_q.ctrl_en);

        // R9: the offered ID must be one that qualifies
        a_r9_pick_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
            pick_hit[c] |-> elig[c][pick_id[c]]);

        // R10: an acknowledged ID is not offered again on the next cycle
        a_r10_ack_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_ack[c] && fwd_valid[c]) |=>
            !(fwd_valid[c] && fwd_id[c*ID_W +: ID_W] == $past(fwd_id[c*ID_W +: ID_W])));
    end

    // R2: a clear-view write leaves none of the written bits enabled
    a_r2_clear_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == {WIN_ENCLR, 3'd1}) |=>
        ((st_q.en_sh[31:0] & $past(bus_wdata)) == 32'd0));

    // R6: the type word reports the implemented line count
    a_r6_type_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_TYPE) |=> (bus_rdata == 32'(NUM_IDS / 32 - 1)));

    // R11: priority words beyond the last ID read as zero
    a_r11_prio_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[7:5] == WIN_PRIO && bus_addr[4:0] >= 5'(NUM_IDS / 4)) |=>
        (bus_rdata == 32'd0));

endmodule

// File: tb/test_irq_distributor.sv
`timescale 1ns/1ps
module test_irq_distributor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  bus_cpu = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [1:0]  cpu_ack = '0;
    logic [1:0]  cpu_eoi = '0;
    logic [11:0] cpu_eoi_id = '0;
    logic [1:0]  fwd_valid;
    logic [11:0] fwd_id;
    logic [15:0] fwd_prio;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_distributor i_irq_distributor (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio)
    );

    typedef struct packed {
        logic        rd;
        logic [0:0]  cpu;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h01, 32'h0,        32'h1,        4'd6},   // R6 type word
        '{1'b1, 1'b0, 8'h00, 32'h0,        32'h0,        4'd1},   // R1 reset value
        '{1'b0, 1'b0, 8'h10, 32'h5,        32'h0,        4'd2},   // R2 set view
        '{1'b1, 1'b0, 8'h10, 32'h0,        32'h5,        4'd2},
        '{1'b0, 1'b0, 8'h11, 32'h80000001, 32'h0,        4'd2},
        '{1'b1, 1'b0, 8'h19, 32'h0,        32'h80000001, 4'd2},   // R2 clear view reads
        '{1'b0, 1'b0, 8'h19, 32'h1,        32'h0,        4'd2},
        '{1'b1, 1'b0, 8'h11, 32'h0,        32'h80000000, 4'd2},
        '{1'b0, 1'b0, 8'h11, 32'h0,        32'h0,        4'd2},   // R2 zeros no effect
        '{1'b1, 1'b0, 8'h11, 32'h0,        32'h80000000, 4'd2},
        '{1'b1, 1'b1, 8'h10, 32'h0,        32'h0,        4'd7},   // R7 other bank clean
        '{1'b0, 1'b1, 8'h10, 32'h100,      32'h0,        4'd7},
        '{1'b1, 1'b1, 8'h18, 32'h0,        32'h100,      4'd7},
        '{1'b1, 1'b0, 8'h10, 32'h0,        32'h5,        4'd7},
        '{1'b0, 1'b0, 8'h41, 32'h44332211, 32'h0,        4'd3},   // R3 priority bytes
        '{1'b1, 1'b0, 8'h41, 32'h0,        32'h44332211, 4'd3},
        '{1'b0, 1'b0, 8'h68, 32'h02010302, 32'h0,        4'd4},   // R4 shared routing
        '{1'b1, 1'b0, 8'h68, 32'h0,        32'h02010302, 4'd4},
        '{1'b0, 1'b1, 8'h60, 32'hffffffff, 32'h0,        4'd4},   // R4 private routing
        '{1'b1, 1'b1, 8'h60, 32'h0,        32'h02020202, 4'd4},
        '{1'b0, 1'b0, 8'h82, 32'haaaaaaaa, 32'h0,        4'd5},   // R5 trigger fields
        '{1'b1, 1'b0, 8'h82, 32'h0,        32'haaaaaaaa, 4'd5},
        '{1'b0, 1'b0, 8'h80, 32'hffffffff, 32'h0,        4'd5},   // R5 private words
        '{1'b1, 1'b0, 8'h80, 32'h0,        32'h0,        4'd5},
        '{1'b1, 1'b0, 8'h12, 32'h0,        32'h0,        4'd11},  // R11 enable hole
        '{1'b0, 1'b0, 8'h50, 32'h12345678, 32'h0,        4'd11},
        '{1'b1, 1'b0, 8'h50, 32'h0,        32'h0,        4'd11}   // R11 priority hole
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [0:0] c, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = c; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [0:0] c, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = c; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack(input int c);
        @(negedge clk); cpu_ack[c] = 1'b1;
        @(negedge clk); cpu_ack[c] = 1'b0;
    endtask

    task automatic eoi(input int c, input logic [5:0] id);
        @(negedge clk); cpu_eoi[c] = 1'b1; cpu_eoi_id[c*6 +: 6] = id;
        @(negedge clk); cpu_eoi[c] = 1'b0;
    endtask

    task automatic chk_fwd(input string tag, input int c, input logic v,
                           input logic [5:0] id, input logic [7:0] pr);
        check({tag, " valid"}, 32'(fwd_valid[c]), 32'(v));
        if (v) begin
            check({tag, " id"}, 32'(fwd_id[c*6 +: 6]), 32'(id));
            check({tag, " prio"}, 32'(fwd_prio[c*8 +: 8]), 32'(pr));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0; cpu_ack = '0; cpu_eoi = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // reset state of the outputs (R1)
        chk_fwd("R1 reset cpu0", 0, 1'b0, 6'd0, 8'd0);
        chk_fwd("R1 reset cpu1", 1, 1'b0, 6'd0, 8'd0);

        // register vector table
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].rd) begin
                rd(VECS[k].cpu, VECS[k].addr, d);
                check($sformatf("R%0d vector %0d", VECS[k].req, k), d, VECS[k].exp);
            end else begin
                wr(VECS[k].cpu, VECS[k].addr, VECS[k].data);
            end
        end

        // R1 gate, R9 offer, R4 routing, R10 level flow
        do_reset();
        wr(0, 8'h11, 32'h2);          // enable ID 33
        wr(0, 8'h48, 32'h00002000);   // ID 33 priority 0x20
        wr(0, 8'h68, 32'h00000100);   // ID 33 to CPU 0
        @(negedge clk); irq_in[1] = 1'b1;
        tick(3);
        chk_fwd("R1 gated", 0, 1'b0, 6'd0, 8'd0);
        wr(0, 8'h00, 32'h1);
        chk_fwd("R9 single", 0, 1'b1, 6'd33, 8'h20);
        chk_fwd("R4 not routed", 1, 1'b0, 6'd0, 8'd0);
        ack(0);
        chk_fwd("R10 active hidden", 0, 1'b0, 6'd0, 8'd0);
        eoi(0, 6'd33);
        chk_fwd("R10 level again", 0, 1'b1, 6'd33, 8'h20);
        ack(0);
        irq_in[1] = 1'b0;
        eoi(0, 6'd33);
        tick(2);
        chk_fwd("R10 level dropped", 0, 1'b0, 6'd0, 8'd0);

        // R9 ordering by priority then ID
        wr(0, 8'h48, 32'h10102000);   // 32:00 33:20 34:10 35:10
        wr(0, 8'h11, 32'h0000000e);   // enable 33..35
        wr(0, 8'h68, 32'h01010100);
        @(negedge clk); irq_in[3:1] = 3'b111;
        tick(2);
        chk_fwd("R9 tie low id", 0, 1'b1, 6'd34, 8'h10);
        ack(0);
        chk_fwd("R9 next tie", 0, 1'b1, 6'd35, 8'h10);
        ack(0);
        chk_fwd("R9 last", 0, 1'b1, 6'd33, 8'h20);
        ack(0);
        chk_fwd("R10 all active", 0, 1'b0, 6'd0, 8'd0);
        eoi(0, 6'd34);
        chk_fwd("R10 release one", 0, 1'b1, 6'd34, 8'h10);

        // R5 edge mode on ID 40 routed to CPU 1
        do_reset();
        wr(0, 8'h82, 32'h00020000);
        wr(0, 8'h11, 32'h00000100);
        wr(0, 8'h6a, 32'h00000002);
        wr(0, 8'h00, 32'h1);
        @(negedge clk); irq_in[8] = 1'b1;
        @(negedge clk); irq_in[8] = 1'b0;
        tick(2);
        chk_fwd("R5 edge latched", 1, 1'b1, 6'd40, 8'h00);
        chk_fwd("R4 other cpu", 0, 1'b0, 6'd0, 8'd0);
        ack(1);
        chk_fwd("R10 edge acked", 1, 1'b0, 6'd0, 8'd0);
        eoi(1, 6'd40);
        tick(1);
        chk_fwd("R5 no new edge", 1, 1'b0, 6'd0, 8'd0);

        // R8 software interrupts on banked private IDs (R7)
        wr(1, 8'h10, 32'h20);
        wr(0, 8'h10, 32'h20);
        wr(0, 8'h02, 32'h00020005);
        chk_fwd("R8 to cpu1", 1, 1'b1, 6'd5, 8'h00);
        chk_fwd("R7 cpu0 untouched", 0, 1'b0, 6'd0, 8'd0);
        wr(0, 8'h02, 32'h00030005);
        chk_fwd("R8 to cpu0", 0, 1'b1, 6'd5, 8'h00);
        rd(1, 8'h10, d);
        check("R7 bank read", d, 32'h20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule